// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number when the translation cache in front of a core misses. It reads two page table entries from untranslated physical memory. The first read fetches a first-level entry through the root table pointer. If that entry is valid, the second read fetches the leaf entry from the table it points to. The walker then returns the frame number and the attribute bits so that the translation cache can be refilled. If either entry is invalid, it returns a page-fault indication instead.

The requester gives a one-cycle start pulse with the 20-bit virtual page number and the root table base. The walker makes its reads through a request/acknowledge memory port, and read data is taken in the cycle of the acknowledge. Each walk ends with a one-cycle done pulse. Fault handling, swapping and any data cache are left to other blocks.

Top module: `pt_walker`

## Requirements
- R1: Out of reset, `busy`, `done`, `fault` and `mem_req` are all 0.
- R2: The first read of a walk goes to `root_base + vpn[19:10]*4`.
- R3: The second read goes to `{L1[31:12], 12'h000} + vpn[9:0]*4`. Here L1 is the first-level entry that was read.
- R4: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` does not change.
- R5: If the first-level entry has bit 0 (valid) clear, the walk ends with `done` and `fault` in the cycle after its acknowledge. No second read is issued.
- R6: If the second-level entry has bit 0 clear, the walk ends with `done` and `fault` in the cycle after its acknowledge. In that cycle `attr` is 0.
- R7: On success, `done` rises in the cycle after the second acknowledge with `fault` = 0. `ppn` equals L2[31:12]. `attr` equals L2[11:1], so `attr[0]` is the writable bit (entry bit 1) and `attr[1]` is the user bit (entry bit 2).
- R8: A `start` pulse while `busy` is high is ignored. The current walk completes unchanged, and no extra walk follows.
- R9: `done` is high for exactly one cycle per walk, and `fault` is high only together with `done`.
- R10: `root_base` and `vpn` are sampled only in the cycle `start` is accepted. Changing them later has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Walk request pulse, accepted only while idle |
| vpn | input | 20 | Virtual page number (address bits 31:12) |
| root_base | input | 32 | Physical byte address of the root table |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Page fault, valid with done |
| ppn | output | 20 | Physical page number, valid with done when fault is 0 |
| attr | output | 11 | Leaf entry bits 11:1 (bit 0 writable, bit 1 user) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Physical byte address of the entry being read |
| mem_ack | input | 1 | Read acknowledge, with data in the same cycle |
| mem_rdata | input | 32 | Entry read data |

## Verification
The bound checker checks on every cycle that the first and second read addresses follow from the accepted page number, root and first-level entry. It also checks that a pending request holds its address, that an invalid entry leads straight to a faulting done, and that done and fault are single-cycle pulses. Some behaviours can only be shown by the bench's directed scenarios. These are the returned frame and attribute values, the absence of a second read after a first-level fault, and the ignoring of a start or of root and page number changes during a walk. The scenarios also cover the extreme indices 0 and 1023 and different memory latencies.

// File: rtl/pt_walk_pkg.sv
// Shared types and entry field positions for the page table walker.
// Assumes one valid bit, one writable bit and one user bit at the bottom of each entry.
package pt_walk_pkg;
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_L1   = 2'd1,
        WS_L2   = 2'd2,
        WS_RESP = 2'd3
    } walk_state_t;

    localparam int ENT_VALID_BIT = 0;
    localparam int ENT_WR_BIT    = 1;
    localparam int ENT_USER_BIT  = 2;
endpackage

// File: rtl/pt_addr_gen.sv
// Entry address generator: picks the table base and the index for the current
// level and forms base + index * entry size. Purely combinational.
// Assumes page-aligned second-level tables and entries of 2**ENT_LG bytes.
module pt_addr_gen #(
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 32,
    parameter int ENT_LG = 2
) (
    input  logic                    sel_l2,
    input  logic [2*IDX_W-1:0]      vpn,
    input  logic [PA_W-1:0]         root_base,
    input  logic [PA_W-OFF_W-1:0]   tbl_frame,
    output logic [PA_W-1:0]         addr
);
    logic [IDX_W-1:0] idx;
    logic [PA_W-1:0]  base;

    // Choose index and base for the level being read.
    always_comb begin
        if (sel_l2) begin
            idx  = vpn[IDX_W-1:0];
            base = {tbl_frame, {OFF_W{1'b0}}};
        end else begin
            idx  = vpn[2*IDX_W-1:IDX_W];
            base = root_base;
        end
        addr = base + (PA_W'(idx) << ENT_LG);
    end
endmodule

// File: rtl/pt_entry_dec.sv
// Entry decoder: splits a page table entry into valid flag, frame number and
// attribute bits (everything between the valid bit and the frame field).
module pt_entry_dec #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input  logic [PA_W-1:0]       ent,
    output logic                  ent_valid,
    output logic [PA_W-OFF_W-1:0] ent_frame,
    output logic [OFF_W-2:0]      ent_attr
);
    import pt_walk_pkg::*;

    // Field extraction.
    always_comb begin
        ent_valid = ent[ENT_VALID_BIT];
        ent_frame = ent[PA_W-1:OFF_W];
        ent_attr  = ent[OFF_W-1:ENT_VALID_BIT+1];
    end
endmodule

// File: rtl/pt_walk_fsm.sv
// Walk sequencer: accepts a start while idle, issues the first- and
// second-level reads, aborts on an invalid entry and presents the result
// for one cycle. Assumes read data is valid in the cycle of mem_ack.
module pt_walk_fsm #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2*IDX_W-1:0]      vpn,
    input  logic [PA_W-1:0]         root_base,
    input  logic                    mem_ack,
    input  logic                    ent_valid,
    input  logic [PA_W-OFF_W-1:0]   ent_frame,
    input  logic [OFF_W-2:0]        ent_attr,
    output logic                    sel_l2,
    output logic                    mem_req,
    output logic                    busy,
    output logic                    done,
    output logic                    fault,
    output logic [PA_W-OFF_W-1:0]   ppn,
    output logic [OFF_W-2:0]        attr,
    output logic [2*IDX_W-1:0]      vpn_q,
    output logic [PA_W-1:0]         root_q,
    output logic [PA_W-OFF_W-1:0]   tbl_q
);
    import pt_walk_pkg::*;

    walk_state_t state;
    logic        fault_q;

    // State sequencing and capture of request, table base and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= WS_IDLE;
            fault_q <= 1'b0;
            vpn_q   <= '0;
            root_q  <= '0;
            tbl_q   <= '0;
            ppn     <= '0;
            attr    <= '0;
        end else begin
            case (state)
                WS_IDLE: if (start) begin
                    vpn_q  <= vpn;
                    root_q <= root_base;
                    state  <= WS_L1;
                end
                WS_L1: if (mem_ack) begin
                    if (ent_valid) begin
                        tbl_q <= ent_frame;
                        state <= WS_L2;
                    end else begin
                        fault_q <= 1'b1;
                        attr    <= '0;
                        state   <= WS_RESP;
                    end
                end
                WS_L2: if (mem_ack) begin
                    fault_q <= !ent_valid;
                    ppn     <= ent_frame;
                    attr    <= ent_valid ? ent_attr : '0;
                    state   <= WS_RESP;
                end
                default: begin
                    fault_q <= 1'b0;
                    state   <= WS_IDLE;
                end
            endcase
        end
    end

    // Decoded outputs from the current state.
    always_comb begin
        sel_l2  = (state == WS_L2);
        mem_req = (state == WS_L1) || (state == WS_L2);
        busy    = (state != WS_IDLE);
        done    = (state == WS_RESP);
        fault   = done && fault_q;
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top. Wires the sequencer, the entry decoder and
// the address generator. Assumes tables live in untranslated physical memory.
module pt_walker #(
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 32,
    parameter int ENT_LG = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2*IDX_W-1:0]      vpn,
    input  logic [PA_W-1:0]         root_base,
    output logic                    busy,
    output logic                    done,
    output logic                    fault,
    output logic [PA_W-OFF_W-1:0]   ppn,
    output logic [OFF_W-2:0]        attr,
    output logic                    mem_req,
    output logic [PA_W-1:0]         mem_addr,
    input  logic                    mem_ack,
    input  logic [PA_W-1:0]         mem_rdata
);
    localparam int VPN_W = 2 * IDX_W;
    localparam int PPN_W = PA_W - OFF_W;

    logic             sel_l2;
    logic             ent_valid;
    logic [PPN_W-1:0] ent_frame;
    logic [OFF_W-2:0] ent_attr;
    logic [VPN_W-1:0] vpn_q;
    logic [PA_W-1:0]  root_q;
    logic [PPN_W-1:0] tbl_q;

    pt_entry_dec #(.OFF_W(OFF_W), .PA_W(PA_W)) u_dec (
        .ent       (mem_rdata),
        .ent_valid (ent_valid),
        .ent_frame (ent_frame),
        .ent_attr  (ent_attr)
    );

    pt_walk_fsm #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vpn       (vpn),
        .root_base (root_base),
        .mem_ack   (mem_ack),
        .ent_valid (ent_valid),
        .ent_frame (ent_frame),
        .ent_attr  (ent_attr),
        .sel_l2    (sel_l2),
        .mem_req   (mem_req),
        .busy      (busy),
        .done      (done),
        .fault     (fault),
        .ppn       (ppn),
        .attr      (attr),
        .vpn_q     (vpn_q),
        .root_q    (root_q),
        .tbl_q     (tbl_q)
    );

    pt_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .ENT_LG(ENT_LG)) u_agen (
        .sel_l2    (sel_l2),
        .vpn       (vpn_q),
        .root_base (root_q),
        .tbl_frame (tbl_q),
        .addr      (mem_addr)
    );
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and address checker for pt_walker. It keeps its own copy of the
// accepted request and first-level frame, and checks the port behaviour against it.
module pt_walker_chk #(
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 32,
    parameter int ENT_LG = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [2*IDX_W-1:0]    vpn,
    input logic [PA_W-1:0]       root_base,
    input logic                  busy,
    input logic                  done,
    input logic                  fault,
    input logic                  mem_req,
    input logic [PA_W-1:0]       mem_addr,
    input logic                  mem_ack,
    input logic                  ent_v,
    input logic [PA_W-OFF_W-1:0] ent_frame
);
    logic [2*IDX_W-1:0]    vpn_l;
    logic [PA_W-1:0]       root_l;
    logic [PA_W-OFF_W-1:0] frame_l;
    logic                  in_l2;

    // Shadow the accepted request and the first-level table frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_l   <= '0;
            root_l  <= '0;
            frame_l <= '0;
            in_l2   <= 1'b0;
        end else begin
            if (start && !busy) begin
                vpn_l  <= vpn;
                root_l <= root_base;
                in_l2  <= 1'b0;
            end else if (mem_req && mem_ack) begin
                if (in_l2) begin
                    in_l2 <= 1'b0;
                end else if (ent_v) begin
                    in_l2   <= 1'b1;
                    frame_l <= ent_frame;
                end
            end
        end
    end

    // R2
    l1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> mem_addr == root_l + (PA_W'(vpn_l[2*IDX_W-1:IDX_W]) << ENT_LG));

    // R3
    l2_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_l2 && mem_req) |-> mem_addr == {frame_l, {OFF_W{1'b0}}} + (PA_W'(vpn_l[IDX_W-1:0]) << ENT_LG));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5 R6
    bad_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !ent_v) |=> (done && fault));

    // R9
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    walk_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind pt_walker pt_walker_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .ENT_LG(ENT_LG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vpn       (vpn),
    .root_base (root_base),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .ent_v     (mem_rdata[0]),
    .ent_frame (mem_rdata[PA_W-1:OFF_W])
);

// File: tb/pt_walker_tb.sv
// Directed bench for pt_walker: a sparse memory model with adjustable latency,
// one task per scenario.
module pt_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] vpn = '0;
    logic [31:0] root_base = '0;
    logic        busy, done, fault, mem_req;
    logic [19:0] ppn;
    logic [10:0] attr;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] pmem [logic [31:0]];
    int          lat = 0;
    int          wcnt = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [4];
    int          unstable = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    // walk results
    logic        r_done, r_fault, r_after_done, r_after_busy;
    logic [19:0] r_ppn;
    logic [10:0] r_attr;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vpn(vpn), .root_base(root_base),
        .busy(busy), .done(done), .fault(fault), .ppn(ppn), .attr(attr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: responds after lat waiting cycles, logs every read.
    initial begin
        forever begin
            @(negedge clk);
            if (pend && mem_req && mem_addr != pend_addr) unstable++;
            if (mem_req) begin
                if (wcnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 32'h0;
                    if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
                    rd_cnt++;
                    wcnt = 0;
                end else begin
                    mem_ack = 1'b0;
                    wcnt++;
                end
            end else begin
                mem_ack = 1'b0;
                wcnt = 0;
            end
            pend      = mem_req && !mem_ack;
            pend_addr = mem_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one walk; optionally disturb inputs mid-walk.
    task automatic run_walk(input logic [19:0] v, input logic [31:0] root,
                            input int l, input bit disturb);
        lat = l;
        rd_cnt = 0;
        unstable = 0;
        r_done = 1'b0;
        @(negedge clk);
        start = 1'b1; vpn = v; root_base = root;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            vpn = ~v; root_base = root ^ 32'h0F0F_0000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 100; i++) begin
            if (done) begin
                r_done = 1'b1; r_fault = fault; r_ppn = ppn; r_attr = attr;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        r_after_done = done;
        r_after_busy = busy;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", 32'(done), 0);
        chk(fault == 1'b0, "R1", "fault after reset", 32'(fault), 0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_basic();
        pmem[32'h0001_0120] = 32'h0002_0001;
        pmem[32'h0002_0D14] = 32'hABCD_E007;
        run_walk(20'h12345, 32'h0001_0000, 0, 1'b0);
        chk(rd_cnt == 2, "R3", "read count", 32'(rd_cnt), 2);
        chk(rd_addr[0] == 32'h0001_0120, "R2", "first address", rd_addr[0], 32'h0001_0120);
        chk(rd_addr[1] == 32'h0002_0D14, "R3", "second address", rd_addr[1], 32'h0002_0D14);
        chk(r_done && !r_fault, "R7", "done without fault", 32'({r_done, r_fault}), 32'h2);
        chk(r_ppn == 20'hABCDE, "R7", "ppn", 32'(r_ppn), 32'hABCDE);
        chk(r_attr == 11'h003, "R7", "attr", 32'(r_attr), 32'h003);
        chk(!r_after_done && !r_after_busy, "R9", "done one cycle", 32'({r_after_done, r_after_busy}), 0);
    endtask

    task automatic t_latency();
        pmem[32'h0004_0008] = 32'h0005_0001;
        pmem[32'h0005_0010] = 32'h5555_5A45;
        run_walk(20'h00804, 32'h0004_0000, 3, 1'b0);
        chk(unstable == 0, "R4", "address changes while pending", 32'(unstable), 0);
        chk(rd_addr[0] == 32'h0004_0008, "R2", "first address slow", rd_addr[0], 32'h0004_0008);
        chk(rd_addr[1] == 32'h0005_0010, "R3", "second address slow", rd_addr[1], 32'h0005_0010);
        chk(r_done && !r_fault && r_ppn == 20'h55555, "R7", "ppn slow", 32'(r_ppn), 32'h55555);
        chk(r_attr == 11'h522, "R7", "attr slow", 32'(r_attr), 32'h522);
    endtask

    task automatic t_l1_fault();
        run_walk(20'h3A000, 32'h0006_0000, 1, 1'b0);
        chk(r_done && r_fault, "R5", "fault on first level", 32'({r_done, r_fault}), 32'h3);
        chk(rd_cnt == 1, "R5", "only one read", 32'(rd_cnt), 1);
        chk(!r_after_done, "R9", "fault done one cycle", 32'(r_after_done), 0);
    endtask

    task automatic t_l2_fault();
        pmem[32'h0007_0004] = 32'h0008_0001;
        pmem[32'h0008_0008] = 32'h7777_7006;
        run_walk(20'h00402, 32'h0007_0000, 0, 1'b0);
        chk(r_done && r_fault, "R6", "fault on second level", 32'({r_done, r_fault}), 32'h3);
        chk(rd_cnt == 2, "R6", "two reads", 32'(rd_cnt), 2);
        chk(r_attr == 11'h0, "R6", "attr cleared", 32'(r_attr), 0);
    endtask

    task automatic t_busy_start();
        run_walk(20'h12345, 32'h0001_0000, 4, 1'b1);
        chk(rd_addr[0] == 32'h0001_0120, "R10", "first address kept", rd_addr[0], 32'h0001_0120);
        chk(r_done && !r_fault && r_ppn == 20'hABCDE, "R10", "result kept", 32'(r_ppn), 32'hABCDE);
        chk(rd_cnt == 2, "R8", "start during walk ignored", 32'(rd_cnt), 2);
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req, "R8", "no extra walk", 32'({busy, mem_req}), 0);
    endtask

    task automatic t_edges();
        pmem[32'h000F_FFFC] = 32'h0030_0001;
        pmem[32'h0030_0FFC] = 32'hFFFF_F003;
        run_walk(20'hFFFFF, 32'h000F_F000, 0, 1'b0);
        chk(rd_addr[0] == 32'h000F_FFFC, "R2", "top first index", rd_addr[0], 32'h000F_FFFC);
        chk(rd_addr[1] == 32'h0030_0FFC, "R3", "top second index", rd_addr[1], 32'h0030_0FFC);
        chk(r_ppn == 20'hFFFFF && r_attr == 11'h001, "R7", "top ppn", 32'(r_ppn), 32'hFFFFF);
        pmem[32'h0009_0000] = 32'h000A_0001;
        pmem[32'h000A_0000] = 32'h0000_1005;
        run_walk(20'h00000, 32'h0009_0000, 2, 1'b0);
        chk(rd_addr[0] == 32'h0009_0000 && rd_addr[1] == 32'h000A_0000, "R3", "zero indices",
            rd_addr[1], 32'h000A_0000);
        chk(r_ppn == 20'h00001 && r_attr == 11'h002, "R7", "zero index ppn", 32'(r_ppn), 32'h1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_latency();
        t_l1_fault();
        t_l2_fault();
        t_busy_start();
        t_edges();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule